// File: doc/BRIEF.md
# Binary Phase-Keyed Carrier Phase Generator

This block produces the phase word that drives a phase-to-amplitude converter in a direct digital synthesis chain. A 48-bit accumulator advances by a carrier tuning word on every clock. The upper 14 bits of the accumulator are added to a phase offset. In binary keying mode, an external data input picks that offset in real time from one of two programmed offset registers, so the carrier's phase flips at the data rate.

The tuning word, both offsets and a 3-bit mode field arrive on shadow inputs. They take effect together only on a clock edge where the update strobe is high. The default mode is a plain single tone, which always uses offset A. Software can still produce arbitrary phase steps in that mode by reloading offset A through repeated updates. The keying input comes from outside the clock domain, so it passes through a two-flop synchronizer before it reaches the adder.

Top module: `bpsk_phase_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the accumulator, the active tuning word, both active offsets, the active mode (to 3'b000) and the synchronizer. After reset, phase_word is 0 and stays 0 until an update loads a nonzero tuning word or offset.
- R2: At every rising edge out of reset, the accumulator adds the active tuning word, modulo 2^48.
- R3: phase_word is the accumulator's bits [47:34] plus the selected offset, modulo 2^14, so it wraps past 16383.
- R4: The shadow inputs carrier_ftw, offset_a, offset_b and mode_sel have no effect until an edge where update_strobe is high. From that edge on, all four are active together. The new tuning word is first added at the following edge.
- R5: In mode 3'b100, a synchronized key level of 0 selects offset A and a level of 1 selects offset B.
- R6: In any mode other than 3'b100, including the default 3'b000 single tone, key_in is ignored and offset A is used.
- R7: A change on key_in that is stable before rising edge n shows on phase_word after rising edge n+1 and not earlier.
- R8: In single-tone mode, reloading offset A with an update steps the output phase by the new offset from the update edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| update_strobe | input | 1 | Transfers all shadow inputs into the active registers |
| carrier_ftw | input | 48 | Shadow carrier tuning word |
| offset_a | input | 14 | Shadow phase offset A |
| offset_b | input | 14 | Shadow phase offset B |
| mode_sel | input | 3 | Shadow mode; 3'b100 enables binary keying |
| key_in | input | 1 | Asynchronous keying data |
| phase_word | output | 14 | Phase word for the amplitude converter |

## Verification
Two events can land on the same edge: a transition on the keying input and an update strobe that rewrites the offset that input is about to select. The bench raises key_in and loads a new offset B on the same edge. It then expects the old offset A to hold for one more edge and the new offset B to appear after the second edge, which shows the new value and not the stale one. A cycle-accurate model applies every vector from the table and raises a mismatch on any edge where the two disagree.

// File: rtl/bpsk_pkg.sv
package bpsk_pkg;
    localparam int MODE_W = 3;
    typedef logic [MODE_W-1:0] mode_t;
    localparam mode_t MODE_TONE = 3'b000;
    localparam mode_t MODE_BPSK = 3'b100;
endpackage

// File: rtl/bpsk_cfg_bank.sv
module bpsk_cfg_bank
    import bpsk_pkg::*;
#(
    parameter int ACC_W = 48,
    parameter int PH_W  = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             update,
    input  logic [ACC_W-1:0] ftw_in,
    input  logic [PH_W-1:0]  ofs_a_in,
    input  logic [PH_W-1:0]  ofs_b_in,
    input  mode_t            mode_in,
    output logic [ACC_W-1:0] ftw_o,
    output logic [PH_W-1:0]  ofs_a_o,
    output logic [PH_W-1:0]  ofs_b_o,
    output mode_t            mode_o
);
    typedef struct packed {
        logic [ACC_W-1:0] ftw;
        logic [PH_W-1:0]  ofs_a;
        logic [PH_W-1:0]  ofs_b;
        mode_t            mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (update) begin
            cfg_d.ftw   = ftw_in;
            cfg_d.ofs_a = ofs_a_in;
            cfg_d.ofs_b = ofs_b_in;
            cfg_d.mode  = mode_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign ftw_o   = cfg_q.ftw;
    assign ofs_a_o = cfg_q.ofs_a;
    assign ofs_b_o = cfg_q.ofs_b;
    assign mode_o  = cfg_q.mode;

    // R4: active set moves only on an update edge
    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!update) |=> $stable(cfg_q));
    assert_cfg_load_R4: assert property (@(posedge clk) disable iff (rst)
        (update) |=> (ftw_o == $past(ftw_in) && ofs_a_o == $past(ofs_a_in)
                      && ofs_b_o == $past(ofs_b_in) && mode_o == $past(mode_in)));
endmodule

// File: rtl/bpsk_key_sync.sv
module bpsk_key_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic key_async,
    output logic key_sync
);
    logic [STAGES-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = {stage_q[STAGES-2:0], key_async};
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    assign key_sync = stage_q[STAGES-1];

    // R7: first stage captures the raw input on each edge
    assert_first_stage_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stage_q[0] == $past(key_async)));
endmodule

// File: rtl/bpsk_phase_acc.sv
module bpsk_phase_acc
    import bpsk_pkg::*;
#(
    parameter int ACC_W = 48,
    parameter int PH_W  = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] ftw,
    input  logic [PH_W-1:0]  ofs_a,
    input  logic [PH_W-1:0]  ofs_b,
    input  mode_t            mode,
    input  logic             key_s,
    output logic [PH_W-1:0]  phase,
    output logic [PH_W-1:0]  acc_top
);
    localparam int TOP_LSB = ACC_W - PH_W;

    logic [ACC_W-1:0] acc_d, acc_q;
    logic             pick_b;
    logic [PH_W-1:0]  ofs_sel;

    always_comb begin
        acc_d   = acc_q + ftw;
        pick_b  = (mode == MODE_BPSK) && key_s;
        ofs_sel = pick_b ? ofs_b : ofs_a;
        acc_top = acc_q[ACC_W-1:TOP_LSB];
        phase   = acc_top + ofs_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    // R2: accumulator steps by the tuning word active on the previous edge
    assert_acc_step_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (acc_q == $past(acc_q + ftw)));
endmodule

// File: rtl/bpsk_phase_gen.sv
module bpsk_phase_gen
    import bpsk_pkg::*;
#(
    parameter int ACC_W     = 48,
    parameter int PH_W      = 14,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             update_strobe,
    input  logic [ACC_W-1:0] carrier_ftw,
    input  logic [PH_W-1:0]  offset_a,
    input  logic [PH_W-1:0]  offset_b,
    input  logic [2:0]       mode_sel,
    input  logic             key_in,
    output logic [PH_W-1:0]  phase_word
);
    logic [ACC_W-1:0] ftw_q;
    logic [PH_W-1:0]  ofs_a_q, ofs_b_q, acc_top;
    mode_t            mode_q;
    logic             key_s;

    bpsk_cfg_bank #(.ACC_W(ACC_W), .PH_W(PH_W)) u_cfg (
        .clk(clk), .rst(rst), .update(update_strobe),
        .ftw_in(carrier_ftw), .ofs_a_in(offset_a), .ofs_b_in(offset_b),
        .mode_in(mode_sel),
        .ftw_o(ftw_q), .ofs_a_o(ofs_a_q), .ofs_b_o(ofs_b_q), .mode_o(mode_q)
    );

    bpsk_key_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst(rst), .key_async(key_in), .key_sync(key_s)
    );

    bpsk_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk(clk), .rst(rst), .ftw(ftw_q), .ofs_a(ofs_a_q), .ofs_b(ofs_b_q),
        .mode(mode_q), .key_s(key_s), .phase(phase_word), .acc_top(acc_top)
    );

    // R6: outside keying mode with a frozen carrier, key_in cannot move the output
    assert_key_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (!update_strobe && ftw_q == '0 && mode_q != MODE_BPSK) |=> $stable(phase_word));
endmodule

// File: tb/bpsk_phase_gen_bench.sv
module bpsk_phase_gen_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        upd;
    logic [47:0] ftw_in;
    logic [13:0] a_in, b_in;
    logic [2:0]  mode_in;
    logic        key;
    logic [13:0] phase_out;

    always #10 clk = ~clk;

    bpsk_phase_gen u_bpsk_phase_gen (
        .clk(clk), .rst(rst), .update_strobe(upd), .carrier_ftw(ftw_in),
        .offset_a(a_in), .offset_b(b_in), .mode_sel(mode_in),
        .key_in(key), .phase_word(phase_out)
    );

    typedef struct packed {
        logic [47:0] ftw;
        logic [13:0] a;
        logic [13:0] b;
        logic [2:0]  mode;
        logic        key;
        logic        upd;
        logic [7:0]  n;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{48'h0004_0000_0000, 14'h0000, 14'h2000, 3'b100, 1'b0, 1'b1, 8'd4},
        '{48'h0004_0000_0000, 14'h0000, 14'h2000, 3'b100, 1'b1, 1'b0, 8'd5},
        '{48'h0004_0000_0000, 14'h0000, 14'h2000, 3'b100, 1'b0, 1'b0, 8'd3},
        '{48'h0003_FFFF_FFFF, 14'h1555, 14'h2AAA, 3'b100, 1'b1, 1'b1, 8'd6},
        '{48'h0003_FFFF_FFFF, 14'h1555, 14'h2AAA, 3'b000, 1'b1, 1'b1, 8'd4},
        '{48'h0003_FFFF_FFFF, 14'h1555, 14'h2AAA, 3'b101, 1'b0, 1'b1, 8'd3},
        '{48'hFFFF_FFFF_FFFF, 14'h0100, 14'h0200, 3'b100, 1'b1, 1'b1, 8'd5},
        '{48'h1234_5678_9ABC, 14'h3FFF, 14'h0001, 3'b100, 1'b0, 1'b1, 8'd5}
    };

    // reference state built from the requirements
    logic [47:0] m_acc, m_ftw;
    logic [13:0] m_a, m_b;
    logic [2:0]  m_mode;
    logic        m_s1, m_s2;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    function automatic logic [13:0] exp_phase();
        return m_acc[47:34] + ((m_mode == 3'b100 && m_s2) ? m_b : m_a);
    endfunction

    task automatic tick();
        logic [47:0] n_acc, n_ftw;
        logic [13:0] n_a, n_b;
        logic [2:0]  n_mode;
        logic        n_s1, n_s2;
        if (rst) begin
            n_acc = '0; n_ftw = '0; n_a = '0; n_b = '0; n_mode = '0; n_s1 = 0; n_s2 = 0;
        end else begin
            n_acc = m_acc + m_ftw;
            n_ftw = upd ? ftw_in : m_ftw;
            n_a = upd ? a_in : m_a;
            n_b = upd ? b_in : m_b;
            n_mode = upd ? mode_in : m_mode;
            n_s1 = key;
            n_s2 = m_s1;
        end
        @(posedge clk);
        m_acc = n_acc; m_ftw = n_ftw; m_a = n_a; m_b = n_b;
        m_mode = n_mode; m_s1 = n_s1; m_s2 = n_s2;
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [13:0] act, logic [13:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: phase_word=%0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick_chk(string tag);
        tick();
        chk(tag, phase_out, exp_phase());
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; upd = 0; ftw_in = '0; a_in = '0; b_in = '0; mode_in = '0; key = 0;
        m_acc = '0; m_ftw = '0; m_a = '0; m_b = '0; m_mode = '0; m_s1 = 0; m_s2 = 0;
        @(negedge clk);
        do_reset();
        chk("R1 reset state", phase_out, 14'd0);

        // table walk: R2 R3 R5 R6 against the model
        for (int i = 0; i < 8; i++) begin
            ftw_in = VEC[i].ftw; a_in = VEC[i].a; b_in = VEC[i].b;
            mode_in = VEC[i].mode; key = VEC[i].key; upd = VEC[i].upd;
            tick_chk("R2/R3/R5/R6 table");
            upd = 0;
            for (int k = 1; k < int'(VEC[i].n); k++) tick_chk("R2/R3/R5/R6 table");
        end

        // R7 exact key latency
        do_reset();
        ftw_in = '0; a_in = 14'd0; b_in = 14'd100; mode_in = 3'b100; key = 0; upd = 1;
        tick(); upd = 0; tick();
        chk("R5 key low picks A", phase_out, 14'd0);
        key = 1; tick();
        chk("R7 not after first edge", phase_out, 14'd0);
        tick();
        chk("R7 after second edge", phase_out, 14'd100);
        key = 0; tick();
        chk("R7 hold on fall", phase_out, 14'd100);
        tick();
        chk("R7 fall after second edge", phase_out, 14'd0);

        // R4 shadow inputs ignored without strobe
        key = 1; tick(); tick();
        a_in = 14'd777; b_in = 14'd555; mode_in = 3'b000; ftw_in = 48'h0004_0000_0000;
        repeat (3) tick();
        chk("R4 shadow ignored", phase_out, 14'd100);
        upd = 1; tick(); upd = 0;
        chk("R4 update edge", phase_out, 14'd777);
        tick();
        chk("R4 tuning word next edge", phase_out, 14'd778);

        // R3 wrap
        do_reset();
        ftw_in = 48'h0004_0000_0000; a_in = 14'h3FFF; mode_in = 3'b000; upd = 1;
        tick(); upd = 0;
        chk("R3 max offset", phase_out, 14'h3FFF);
        tick();
        chk("R3 wrap", phase_out, 14'd0);

        // R8 phase steps in single tone
        for (int s = 1; s < 4; s++) begin
            a_in = 14'(s * 14'h1000); upd = 1;
            tick_chk("R8 tone phase step");
        end
        upd = 0;
        tick_chk("R8 tone hold");

        // update and key edge together (R5 with R4)
        do_reset();
        ftw_in = '0; a_in = 14'd10; b_in = 14'd20; mode_in = 3'b100; key = 0; upd = 1;
        tick(); upd = 0; tick();
        key = 1; b_in = 14'd30; upd = 1; tick(); upd = 0;
        chk("R5 same-edge still A", phase_out, 14'd10);
        tick();
        chk("R5 same-edge new B", phase_out, 14'd30);

        // R1 mid-run reset
        ftw_in = 48'h0004_0000_0000; a_in = 14'd5; mode_in = 3'b000; upd = 1;
        repeat (3) tick(); upd = 0;
        do_reset();
        chk("R1 mid-run reset", phase_out, 14'd0);
        tick();
        chk("R1 tuning word cleared", phase_out, 14'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule